// File: doc/BRIEF.md
# Radix-8 Booth Multiplier for Signed and Unsigned Operands

This block multiplies two 8-bit operands and returns a 16-bit product. A single mode input picks how the operands are read: as two's-complement numbers or as unsigned numbers. Both readings share one datapath. Each operand gets one extra top bit, which copies bit 7 in signed mode and is zero in unsigned mode. The multiplier operand, widened in this way, is recoded into radix-8 digits in the range -4 to +4. Each digit picks a multiple of the widened multiplicand: 0, X, 2X, 3X or 4X. The 3X multiple comes from a dedicated adder.

The partial products are formed in parallel and sign-extended to 16 bits. A negative digit inverts its selected multiple and puts a single correction bit into an extra row at that digit's weight. A carry-save reduction takes all rows down to one sum row and one carry row. A carry-lookahead adder then adds the two, with the carry row shifted one place to the left. The result is captured in an output register that has a synchronous, active-high reset.

Top module: `smul_r8_top`

## Requirements
- R1: With `mode_signed` = 1, `prod_out` equals the low 16 bits of the two's-complement product of `a_in` and `b_in`.
- R2: With `mode_signed` = 0, `prod_out` equals the unsigned product of `a_in` and `b_in`.
- R3: `prod_out` is registered. A result for operands present before a rising clock edge appears at that edge. While `rst` is high at an edge, `prod_out` becomes 0 whatever the operands are.
- R4: For each radix-8 digit, the select vector (bit0 = 1X, bit1 = 2X, bit2 = 3X, bit3 = 4X) has at most one bit set. A negative digit always has a nonzero magnitude. Products whose multiplier yields every digit value from -4 to +4 are correct.
- R5: In unsigned mode the most significant digit is never negative. This holds even when `b_in` has bit 7 set.
- R6: The carry-save reduction preserves the total. The sum row plus twice the carry row equals the sum of all partial-product rows modulo 2^16.
- R7: A zero on either operand gives a zero product in both modes.
- R8: Extreme operands are exact. In signed mode, -128 x -128 = 0x4000, -128 x 127 = 0xC080 and -1 x -1 = 0x0001. In unsigned mode, 255 x 255 = 0xFE01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the output register |
| mode_signed | input | 1 | 1: operands are two's complement; 0: operands are unsigned |
| a_in | input | 8 | Multiplicand |
| b_in | input | 8 | Multiplier, recoded into radix-8 digits |
| prod_out | output | 16 | Registered product |

## Verification
The product assertions assume that `mode_signed`, `a_in` and `b_in` are settled before each rising edge. The result registered at that edge is then compared with the operands sampled there. The stimulus changes inputs only on falling edges and holds them for a full cycle, so every edge sees one consistent operand set. The digit and reduction assertions assume no particular operand values. The exhaustive sweep in both modes therefore reaches every window pattern the encoder can see.

// File: rtl/smul_pkg.sv
package smul_pkg;
  // one-hot magnitude select: bit0=1X, bit1=2X, bit2=3X, bit3=4X
  typedef logic [3:0] sel_t;

  // radix-8 digits needed to cover a w-bit operand plus its extension bit
  function automatic int r8_digits(input int w);
    return (w + 3) / 3;
  endfunction
endpackage

// File: rtl/smul_cla.sv
module smul_cla #(
  parameter int N   = 16,
  parameter int GRP = 4
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         cin,
  output logic [N-1:0] s
);
  localparam int NGRP = N / GRP;

  logic [N-1:0] g, p;
  assign g = a & b;
  assign p = a ^ b;

  always_comb begin
    logic [N:0] c;
    logic t, pr;
    c = '0;
    c[0] = cin;
    for (int gi = 0; gi < NGRP; gi++) begin
      for (int j = 0; j < GRP; j++) begin
        t  = 1'b0;
        pr = 1'b1;
        for (int k = j; k >= 0; k--) begin
          t  = t | (g[gi*GRP+k] & pr);
          pr = pr & p[gi*GRP+k];
        end
        c[gi*GRP+j+1] = t | (pr & c[gi*GRP]);
      end
    end
    s = p ^ c[N-1:0];
  end
endmodule

// File: rtl/smul_booth_enc.sv
module smul_booth_enc #(
  parameter int W = 8
) (
  input  logic                              mode_signed,
  input  logic [W-1:0]                      b,
  output logic [smul_pkg::r8_digits(W)-1:0] neg,
  output smul_pkg::sel_t [smul_pkg::r8_digits(W)-1:0] sel
);
  localparam int NDIG = smul_pkg::r8_digits(W);
  localparam int EB   = 3 * NDIG;

  logic [EB-1:0] bext;
  logic [EB:0]   bpad;
  assign bext = {{(EB-W){mode_signed & b[W-1]}}, b};
  assign bpad = {bext, 1'b0};

  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    logic [3:0] win;
    logic [2:0] lo, mag;
    assign win    = bpad[3*i +: 4];
    assign lo     = {1'b0, win[2], 1'b0} + {2'b0, win[1]} + {2'b0, win[0]};
    assign mag    = win[3] ? (3'd4 - lo) : lo;
    assign neg[i] = win[3] & (lo != 3'd4);
    assign sel[i] = {mag == 3'd4, mag == 3'd3, mag == 3'd2, mag == 3'd1};
  end
endmodule

// File: rtl/smul_pp_sel.sv
module smul_pp_sel #(
  parameter int PW    = 16,
  parameter int SHIFT = 0
) (
  input  logic           neg,
  input  smul_pkg::sel_t sel,
  input  logic [PW-1:0]  m1,
  input  logic [PW-1:0]  m2,
  input  logic [PW-1:0]  m3,
  input  logic [PW-1:0]  m4,
  output logic [PW-1:0]  pp
);
  logic [PW-1:0] mag, inv;
  assign mag = ({PW{sel[0]}} & m1) | ({PW{sel[1]}} & m2) |
               ({PW{sel[2]}} & m3) | ({PW{sel[3]}} & m4);
  assign inv = neg ? ~mag : mag;
  assign pp  = inv << SHIFT;
endmodule

// File: rtl/smul_csa_tree.sv
module smul_csa_tree #(
  parameter int PW   = 16,
  parameter int NROW = 4
) (
  input  logic [NROW-1:0][PW-1:0] rows,
  output logic [PW-1:0]           sum_row,
  output logic [PW-1:0]           carry_row
);
  logic [NROW-2:0][PW-1:0] ss, sh;
  logic [NROW-3:0][PW-1:0] mj;

  assign ss[0] = rows[0];
  assign sh[0] = rows[1];

  for (genvar k = 0; k < NROW - 2; k++) begin : g_lvl
    assign ss[k+1] = ss[k] ^ sh[k] ^ rows[k+2];
    assign mj[k]   = (ss[k] & sh[k]) | (ss[k] & rows[k+2]) | (sh[k] & rows[k+2]);
    assign sh[k+1] = {mj[k][PW-2:0], 1'b0};
  end

  assign sum_row   = ss[NROW-2];
  assign carry_row = mj[NROW-3];
endmodule

// File: rtl/smul_r8_top.sv
module smul_r8_top #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mode_signed,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [2*W-1:0] prod_out
);
  localparam int PW   = 2 * W;
  localparam int NDIG = smul_pkg::r8_digits(W);
  localparam int NROW = NDIG + 1;

  logic signed [W:0] xs;
  logic [PW-1:0] m1, m2, m3, m4;
  logic [NDIG-1:0] dig_neg;
  smul_pkg::sel_t [NDIG-1:0] dig_sel;
  logic [NROW-1:0][PW-1:0] pp_rows;
  logic [PW-1:0] hot_row, csa_sum, csa_carry, prod_c;

  assign xs = {mode_signed & a_in[W-1], a_in};
  assign m1 = PW'(xs);
  assign m2 = m1 << 1;
  assign m4 = m1 << 2;

  smul_cla #(.N(PW)) triple_i (.a(m1), .b(m2), .cin(1'b0), .s(m3));

  smul_booth_enc #(.W(W)) enc_i (
    .mode_signed(mode_signed), .b(b_in), .neg(dig_neg), .sel(dig_sel)
  );

  for (genvar i = 0; i < NDIG; i++) begin : g_pp
    smul_pp_sel #(.PW(PW), .SHIFT(3*i)) sel_i (
      .neg(dig_neg[i]), .sel(dig_sel[i]),
      .m1(m1), .m2(m2), .m3(m3), .m4(m4), .pp(pp_rows[i])
    );
  end

  always_comb begin
    hot_row = '0;
    for (int i = 0; i < NDIG; i++) hot_row[3*i] = dig_neg[i];
  end
  assign pp_rows[NDIG] = hot_row;

  smul_csa_tree #(.PW(PW), .NROW(NROW)) csa_i (
    .rows(pp_rows), .sum_row(csa_sum), .carry_row(csa_carry)
  );

  smul_cla #(.N(PW)) final_i (
    .a(csa_sum), .b({csa_carry[PW-2:0], 1'b0}), .cin(1'b0), .s(prod_c)
  );

  always_ff @(posedge clk) begin
    if (rst) prod_out <= '0;
    else     prod_out <= prod_c;
  end
endmodule

// File: rtl/smul_r8_chk.sv
module smul_r8_chk #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           mode_signed,
  input logic [W-1:0]   a_in,
  input logic [W-1:0]   b_in,
  input logic [2*W-1:0] prod_out,
  input logic [smul_pkg::r8_digits(W)-1:0] dig_neg,
  input smul_pkg::sel_t [smul_pkg::r8_digits(W)-1:0] dig_sel,
  input logic [smul_pkg::r8_digits(W):0][2*W-1:0] pp_rows,
  input logic [2*W-1:0] csa_sum,
  input logic [2*W-1:0] csa_carry
);
  localparam int PW   = 2 * W;
  localparam int NDIG = smul_pkg::r8_digits(W);

  logic signed [W:0]    ax, bx;
  logic signed [PW-1:0] axw, bxw;
  logic [PW-1:0]        expect_p, row_total;

  assign ax  = {mode_signed & a_in[W-1], a_in};
  assign bx  = {mode_signed & b_in[W-1], b_in};
  assign axw = PW'(ax);
  assign bxw = PW'(bx);
  assign expect_p = axw * bxw;

  always_comb begin
    row_total = '0;
    for (int r = 0; r <= NDIG; r++) row_total = row_total + pp_rows[r];
  end

  AST_PROD_SIGNED: assert property (@(posedge clk) disable iff (rst)
    mode_signed |=> prod_out == $past(expect_p)); // R1
  AST_PROD_UNSIGNED: assert property (@(posedge clk) disable iff (rst)
    !mode_signed |=> prod_out == $past(expect_p)); // R2
  AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (rst)
    (a_in == '0 || b_in == '0) |=> prod_out == '0); // R7
  AST_UNS_TOP_DIGIT: assert property (@(posedge clk) disable iff (rst)
    !mode_signed |-> !dig_neg[NDIG-1]); // R5
  AST_CSA_CONSERVE: assert property (@(posedge clk) disable iff (rst)
    PW'(csa_sum + {csa_carry[PW-2:0], 1'b0}) == row_total); // R6

  for (genvar i = 0; i < NDIG; i++) begin : g_dchk
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(dig_sel[i])); // R4
    AST_NEG_HAS_MAG: assert property (@(posedge clk) disable iff (rst)
      dig_neg[i] |-> dig_sel[i] != '0); // R4
  end
endmodule

bind smul_r8_top smul_r8_chk #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .mode_signed(mode_signed), .a_in(a_in), .b_in(b_in),
  .prod_out(prod_out), .dig_neg(dig_neg), .dig_sel(dig_sel),
  .pp_rows(pp_rows), .csa_sum(csa_sum), .csa_carry(csa_carry)
);

// File: tb/smul_r8_top_tb.sv
`timescale 1ns/1ps
module smul_r8_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_signed = 1'b0;
  logic [7:0]  a_in = '0;
  logic [7:0]  b_in = '0;
  logic [15:0] prod_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  smul_r8_top #(.W(8)) dut_i (
    .clk(clk), .rst(rst), .mode_signed(mode_signed),
    .a_in(a_in), .b_in(b_in), .prod_out(prod_out)
  );

  function automatic logic [15:0] ref_mul(input logic [7:0] a, input logic [7:0] b,
                                          input logic m);
    logic signed [15:0] sa, sb;
    if (m) begin
      sa = $signed(a);
      sb = $signed(b);
      return sa * sb;
    end
    return {8'h00, a} * {8'h00, b};
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (a=%h b=%h signed=%0b)",
               req, got, exp, a_in, b_in, mode_signed);
    end
  endtask

  // drive on falling edge, sample 1 ns after the capturing rising edge
  task automatic apply(input logic [7:0] a, input logic [7:0] b, input logic m);
    @(negedge clk);
    a_in = a; b_in = b; mode_signed = m;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    @(posedge clk); #1;
    check("R3 reset", prod_out, 16'h0000);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_latency;
    apply(8'd12, 8'd11, 1'b0);
    check("R3 latency", prod_out, 16'd132);
    @(negedge clk);
    a_in = 8'd3; b_in = 8'd5;
    #0.5;
    check("R3 held", prod_out, 16'd132);
    @(posedge clk); #1;
    check("R3 update", prod_out, 16'd15);
  endtask

  task automatic t_reset_mid;
    @(negedge clk);
    a_in = 8'hA5; b_in = 8'h3C; mode_signed = 1'b1; rst = 1'b1;
    @(posedge clk); #1;
    check("R3 mid reset", prod_out, 16'h0000);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    check("R3 after reset", prod_out, ref_mul(8'hA5, 8'h3C, 1'b1));
  endtask

  task automatic t_corners;
    apply(8'h80, 8'h80, 1'b1); check("R8 -128*-128", prod_out, 16'h4000);
    apply(8'h80, 8'h7F, 1'b1); check("R8 -128*127", prod_out, 16'hC080);
    apply(8'hFF, 8'hFF, 1'b1); check("R8 -1*-1", prod_out, 16'h0001);
    apply(8'hFF, 8'h01, 1'b1); check("R8 -1*1", prod_out, 16'hFFFF);
    apply(8'hFF, 8'hFF, 1'b0); check("R8 255*255", prod_out, 16'hFE01);
    apply(8'h80, 8'h80, 1'b0); check("R8 128*128", prod_out, 16'h4000);
  endtask

  task automatic t_zero;
    for (int m = 0; m < 2; m++) begin
      apply(8'h00, 8'hB7, m[0]); check("R7 a=0", prod_out, 16'h0000);
      apply(8'h9D, 8'h00, m[0]); check("R7 b=0", prod_out, 16'h0000);
    end
  endtask

  // multipliers whose windows give every digit value from -4 to +4
  task automatic t_digits;
    logic [7:0] mv [10] = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05,
                            8'h06, 8'h07, 8'h0C, 8'h1B, 8'hE4};
    for (int m = 0; m < 2; m++)
      for (int k = 0; k < 10; k++) begin
        apply(8'h6B, mv[k], m[0]);
        check("R4 digit set", prod_out, ref_mul(8'h6B, mv[k], m[0]));
      end
  endtask

  task automatic t_unsigned_top;
    for (int a = 1; a < 256; a += 37) begin
      apply(a[7:0], 8'hFF, 1'b0);
      check("R5 top digit", prod_out, 16'(a * 255));
      apply(a[7:0], 8'hC0, 1'b0);
      check("R5 top digit", prod_out, 16'(a * 192));
    end
  endtask

  task automatic t_reduction;
    logic [7:0] av [4] = '{8'h55, 8'hAA, 8'h33, 8'hCC};
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++) begin
        apply(av[i], av[j], 1'b1);
        check("R6 row sum", prod_out, ref_mul(av[i], av[j], 1'b1));
      end
  endtask

  task automatic t_sweep(input logic m);
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++) begin
        apply(a[7:0], b[7:0], m);
        check(m ? "R1 sweep" : "R2 sweep", prod_out, ref_mul(a[7:0], b[7:0], m));
      end
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    t_reset();
    t_latency();
    t_corners();
    t_zero();
    t_digits();
    t_unsigned_top();
    t_reduction();
    t_sweep(1'b1);
    t_sweep(1'b0);
    t_reset_mid();
    finished = 1'b1;
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule